// File: doc/BRIEF.md
# Serial Byte Queue Controller

This block holds the two byte queues that sit between a serial line core and the register bus: a receive queue filled by the deserializer and drained by software, and a transmit queue filled by software and drained by the serializer. Each direction has its own configuration word with an enable bit, a self-clearing discard bit and an interrupt threshold. A shared status word reports the receive fill count, the transmit fill count and the free transmit space.

Software reaches the block through a flat word-addressed register port. Reads are combinational: `reg_rdata` follows `reg_addr` in the same cycle. A read strobe on the receive data address removes one byte at the next clock edge. A write to the transmit data address appends one byte.

The deserializer pushes through a valid/ready stream. `rx_in_ready` depends only on the receive enable and never on the fill level, because a serial receiver cannot be stalled. A byte offered to a full queue is lost and flagged on `rx_overrun`. The serializer pulls through a valid/ready stream. A byte leaves whenever `tx_out_valid` and `tx_out_ready` are both high at a clock edge.

Register map (word address on `reg_addr`):

| Address | Access | Purpose |
|---|---|---|
| 0 | read/write | transmit configuration |
| 1 | read/write | receive configuration |
| 2 | read | status |
| 3 | write | transmit data |
| 4 | read | receive data |

Top module: `serial_fifo_ctrl`

## Requirements
- R1: After reset both queues are disabled and empty. Both configuration words read 0. Status reads 32'h1000_0000, which is 16 free transmit entries and nothing else. `rx_req`, `tx_req`, `rx_in_ready` and `tx_out_valid` are low, and `tx_idle` is high.
- R2: Each queue returns bytes in the order they entered. Receive bytes come out through reads of address 4, and transmit bytes come out on `tx_out_data`.
- R3: Each queue holds at most 16 bytes. A receive push to a full queue is dropped and raises `rx_overrun` in that cycle. A transmit data write to a full queue is dropped. In both cases the count stays at 16.
- R4: The status word at address 2 carries the receive fill count in bits 5:0, the transmit fill count in bits 13:8 and the free transmit entries in bits 29:24. All other bits read 0.
- R5: In each configuration word, bit 0 is the enable and bits 13:8 are the threshold. Both read back as written. Bit 1 (discard) always reads 0.
- R6: Writing bit 1 of a configuration word empties that queue at the clock edge after the write. The count is unchanged just after the write edge and is 0 after the following edge.
- R7: A single configuration write with bit 0 clear and bit 1 set leaves that queue both disabled and empty.
- R8: While a queue is disabled, the following hold:
  - `rx_in_ready` is low.
  - Receive pushes are dropped without `rx_overrun`.
  - `tx_out_valid` is low.
  - Transmit data writes are dropped.
- R9: `rx_req` is high while the receive queue is enabled and its count is at least the receive threshold. `tx_req` is high while the transmit queue is enabled and its free space is at least the transmit threshold.
- R10: A read of address 4 on an empty receive queue returns the last byte removed and leaves the count at 0.
- R11: `tx_idle` is high exactly when the transmit fill count is 0.
- R12: A receive push and a receive data read in the same cycle, on a queue that is neither empty nor full, leave the count unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (pops at address 4) |
| reg_addr | input | 3 | word address |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | combinational read data |
| rx_in_valid | input | 1 | receive byte offered |
| rx_in_ready | output | 1 | receive queue accepting (enable only) |
| rx_in_data | input | 8 | received byte |
| tx_out_valid | output | 1 | transmit byte available |
| tx_out_ready | input | 1 | serializer takes byte |
| tx_out_data | output | 8 | head transmit byte (last removed when empty) |
| rx_req | output | 1 | receive threshold request |
| tx_req | output | 1 | transmit threshold request |
| rx_overrun | output | 1 | push to full receive queue dropped |
| tx_idle | output | 1 | transmit queue empty |

## Verification
The hardest state to reach from the ports is a discard write that lands on a queue still holding data. Meeting it in the same write as disabling the queue is harder still, because pushes and pops have to be stopped so that the one-cycle delay of the discard can be seen. The stimulus first fills a queue to a known count with pushes or data writes. It then issues the configuration write and samples status right after the write edge, when the old count must still show. It samples again one edge later, when the count must be 0. The overrun case is reached by offering a seventeenth byte to a full receive queue and sampling `rx_overrun` before that edge.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int FIELD_W = 6;
  localparam int WORD_W  = 32;

  localparam logic [2:0] ADR_TXCFG = 3'd0;
  localparam logic [2:0] ADR_RXCFG = 3'd1;
  localparam logic [2:0] ADR_STAT  = 3'd2;
  localparam logic [2:0] ADR_TXDAT = 3'd3;
  localparam logic [2:0] ADR_RXDAT = 3'd4;

  localparam int BIT_EN    = 0;
  localparam int BIT_DISC  = 1;
  localparam int LVL_LO    = 8;
  localparam int RXCNT_LO  = 0;
  localparam int TXCNT_LO  = 8;
  localparam int TXFREE_LO = 24;

  typedef struct packed {
    logic               en;
    logic [FIELD_W-1:0] lvl;
  } qcfg_t;
endpackage

// File: rtl/sfifo_cfg_reg.sv
module sfifo_cfg_reg
  import sfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output qcfg_t             cfg,
  output logic              discard
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      discard <= 1'b0;
    end else begin
      discard <= wr && wdata[BIT_DISC];
      if (wr) begin
        cfg.en  <= wdata[BIT_EN];
        cfg.lvl <= wdata[LVL_LO +: FIELD_W];
      end
    end
  end
endmodule

// File: rtl/sfifo_buffer.sv
module sfifo_buffer #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [DATA_W-1:0] last_q;
  logic              do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty && !clear;
  assign head    = empty ? last_q : mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      last_q <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop) begin
        rd_ptr <= nxt(rd_ptr);
        last_q <= mem[rd_ptr];
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/serial_fifo_ctrl.sv
module serial_fifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  output logic              rx_req,
  output logic              tx_req,
  output logic              rx_overrun,
  output logic              tx_idle
);
  qcfg_t             tx_cfg, rx_cfg;
  logic              tx_disc, rx_disc;
  logic [CNT_W-1:0]  tx_count, rx_count;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;
  logic              tx_push, tx_pop, rx_push, rx_pop;
  logic [FIELD_W-1:0] tx_cnt_f, rx_cnt_f, tx_free_f;

  logic sel_txcfg, sel_rxcfg, sel_txdat, sel_rxdat;
  assign sel_txcfg = (reg_addr == ADDR_W'(ADR_TXCFG));
  assign sel_rxcfg = (reg_addr == ADDR_W'(ADR_RXCFG));
  assign sel_txdat = (reg_addr == ADDR_W'(ADR_TXDAT));
  assign sel_rxdat = (reg_addr == ADDR_W'(ADR_RXDAT));

  sfifo_cfg_reg u_txcfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr && sel_txcfg),
    .wdata(reg_wdata), .cfg(tx_cfg), .discard(tx_disc)
  );
  sfifo_cfg_reg u_rxcfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr && sel_rxcfg),
    .wdata(reg_wdata), .cfg(rx_cfg), .discard(rx_disc)
  );

  assign tx_push = reg_wr && sel_txdat && tx_cfg.en;
  assign tx_pop  = tx_out_valid && tx_out_ready;
  assign rx_push = rx_in_valid && rx_in_ready;
  assign rx_pop  = reg_rd && sel_rxdat && rx_cfg.en;

  sfifo_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .clear(tx_disc),
    .push(tx_push), .push_data(reg_wdata[DATA_W-1:0]), .pop(tx_pop),
    .head(tx_out_data), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );
  sfifo_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clear(rx_disc),
    .push(rx_push), .push_data(rx_in_data), .pop(rx_pop),
    .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  assign tx_cnt_f  = FIELD_W'(tx_count);
  assign rx_cnt_f  = FIELD_W'(rx_count);
  assign tx_free_f = FIELD_W'(DEPTH) - tx_cnt_f;

  assign rx_in_ready  = rx_cfg.en;
  assign rx_overrun   = rx_in_valid && rx_cfg.en && rx_full;
  assign tx_out_valid = tx_cfg.en && !tx_empty;
  assign tx_idle      = tx_empty;
  assign rx_req       = rx_cfg.en && (rx_cnt_f >= rx_cfg.lvl);
  assign tx_req       = tx_cfg.en && (tx_free_f >= tx_cfg.lvl);

  function automatic logic [31:0] cfg_word(input qcfg_t c);
    logic [31:0] w;
    w = '0;
    w[BIT_EN] = c.en;
    w[LVL_LO +: FIELD_W] = c.lvl;
    return w;
  endfunction

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(ADR_TXCFG): reg_rdata = cfg_word(tx_cfg);
      ADDR_W'(ADR_RXCFG): reg_rdata = cfg_word(rx_cfg);
      ADDR_W'(ADR_STAT): begin
        reg_rdata[RXCNT_LO  +: FIELD_W] = rx_cnt_f;
        reg_rdata[TXCNT_LO  +: FIELD_W] = tx_cnt_f;
        reg_rdata[TXFREE_LO +: FIELD_W] = tx_free_f;
      end
      ADDR_W'(ADR_RXDAT): reg_rdata[DATA_W-1:0] = rx_head;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sfifo_checker.sv
module sfifo_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [CNT_W-1:0] tx_cnt,
  input logic             rx_overrun,
  input logic             rx_in_valid,
  input logic             tx_out_valid,
  input logic             tx_idle,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= CNT_W'(DEPTH)) && (tx_cnt <= CNT_W'(DEPTH)));

  assert_overrun_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> (rx_cnt == CNT_W'(DEPTH)) && rx_in_valid);

  assert_discard_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && reg_wdata[1]) |=> ##1 (rx_cnt == '0));

  assert_empty_read_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd4 && rx_cnt == '0 && !rx_in_valid) |=> (rx_cnt == '0));

  assert_idle_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> !tx_out_valid);
endmodule

bind serial_fifo_ctrl sfifo_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_cnt(rx_count), .tx_cnt(tx_count),
  .rx_overrun(rx_overrun), .rx_in_valid(rx_in_valid),
  .tx_out_valid(tx_out_valid), .tx_idle(tx_idle),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/serial_fifo_ctrl_test.sv
module serial_fifo_ctrl_test;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        rx_in_valid = 0, rx_in_ready;
  logic [7:0]  rx_in_data = 0;
  logic        tx_out_valid, tx_out_ready = 0;
  logic [7:0]  tx_out_data;
  logic        rx_req, tx_req, rx_overrun, tx_idle;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  serial_fifo_ctrl uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk); reg_wr = 0; reg_addr = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rxpop(output logic [7:0] b);
    @(negedge clk); reg_rd = 1; reg_addr = 3'd4; #1; b = reg_rdata[7:0];
    @(posedge clk); @(negedge clk); reg_rd = 0; reg_addr = 0;
  endtask

  task automatic rxpush(input logic [7:0] b);
    @(negedge clk); rx_in_valid = 1; rx_in_data = b;
    @(posedge clk); @(negedge clk); rx_in_valid = 0;
  endtask

  task automatic txpop(output logic [7:0] b);
    @(negedge clk); tx_out_ready = 1; #1; b = tx_out_data;
    @(posedge clk); @(negedge clk); tx_out_ready = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    peek(3'd2, d); chk(d == 32'h1000_0000, "R1 status", d, 32'h1000_0000);
    peek(3'd0, d); chk(d == 0, "R1 txcfg", d, 0);
    peek(3'd1, d); chk(d == 0, "R1 rxcfg", d, 0);
    chk({rx_req, tx_req, rx_in_ready, tx_out_valid, tx_idle} == 5'b00001, "R1 pins",
        {rx_req, tx_req, rx_in_ready, tx_out_valid, tx_idle}, 5'b00001);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    wr(3'd1, 32'h0000_0403);
    peek(3'd1, d); chk(d == 32'h0000_0401, "R5 rxcfg readback", d, 32'h401);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_rx_order;
    logic [31:0] d; logic [7:0] b;
    for (int i = 0; i < 3; i++) rxpush(8'h10 + 8'(i));
    chk(rx_req == 0, "R9 rx_req below level", rx_req, 0);
    rxpush(8'h13);
    chk(rx_req == 1, "R9 rx_req at level", rx_req, 1);
    peek(3'd2, d); chk(d[5:0] == 4, "R4 rx count field", d, 4);
    for (int i = 0; i < 4; i++) begin
      rxpop(b); chk(b == 8'h10 + 8'(i), "R2 rx order", b, 8'h10 + 8'(i));
    end
    rxpop(b); chk(b == 8'h13, "R10 empty read returns last", b, 8'h13);
    peek(3'd2, d); chk(d[5:0] == 0, "R10 count stays 0", d, 0);
  endtask

  task automatic t_rx_overrun;
    logic [31:0] d; logic [7:0] b;
    for (int i = 0; i < 16; i++) rxpush(8'h40 + 8'(i));
    @(negedge clk); rx_in_valid = 1; rx_in_data = 8'hEE; #1;
    chk(rx_overrun == 1 && rx_in_ready == 1, "R3 overrun on full", rx_overrun, 1);
    @(posedge clk); @(negedge clk); rx_in_valid = 0;
    peek(3'd2, d); chk(d[5:0] == 16, "R3 count stays 16", d, 16);
    // simultaneous push and pop with 16 stored -> pop first to get 15
    rxpop(b); chk(b == 8'h40, "R2 first after overrun", b, 8'h40);
    @(negedge clk); rx_in_valid = 1; rx_in_data = 8'h77; reg_rd = 1; reg_addr = 3'd4; #1;
    b = reg_rdata[7:0]; chk(b == 8'h41, "R12 head during push+pop", b, 8'h41);
    @(posedge clk); @(negedge clk); rx_in_valid = 0; reg_rd = 0;
    peek(3'd2, d); chk(d[5:0] == 15, "R12 count unchanged", d, 15);
    for (int i = 2; i < 16; i++) begin
      rxpop(b); chk(b == 8'h40 + 8'(i), "R3 stored bytes kept", b, 8'h40 + 8'(i));
    end
    rxpop(b); chk(b == 8'h77, "R12 pushed byte last", b, 8'h77);
  endtask

  task automatic t_flush;
    logic [31:0] d;
    for (int i = 0; i < 5; i++) rxpush(8'(i));
    wr(3'd1, 32'h0000_0003);
    peek(3'd2, d); chk(d[5:0] == 5, "R6 count before discard edge", d, 5);
    peek(3'd1, d); chk(d[1] == 0 && d[0] == 1, "R5 discard bit reads 0", d, 1);
    @(posedge clk); @(negedge clk);
    peek(3'd2, d); chk(d[5:0] == 0, "R6 count after discard", d, 0);
    chk(rx_in_ready == 1, "R6 still enabled", rx_in_ready, 1);
  endtask

  task automatic t_tx;
    logic [31:0] d; logic [7:0] b;
    wr(3'd3, 32'hAA);
    peek(3'd2, d); chk(d[13:8] == 0, "R8 tx write dropped when disabled", d, 0);
    wr(3'd0, 32'h0000_0A01);
    chk(tx_req == 1, "R9 tx_req free>=level", tx_req, 1);
    for (int i = 0; i < 7; i++) wr(3'd3, 32'h20 + i);
    peek(3'd2, d); chk(d == 32'h0900_0700, "R4 status tx fields", d, 32'h0900_0700);
    chk(tx_req == 0 && tx_idle == 0, "R9 R11 tx_req low, not idle", {tx_req, tx_idle}, 0);
    for (int i = 0; i < 7; i++) begin
      txpop(b); chk(b == 8'h20 + 8'(i), "R2 tx order", b, 8'h20 + 8'(i));
    end
    chk(tx_idle == 1 && tx_out_valid == 0, "R11 idle after drain", tx_idle, 1);
    for (int i = 0; i < 17; i++) wr(3'd3, 32'h50 + i);
    peek(3'd2, d); chk(d[13:8] == 16 && d[29:24] == 0, "R3 tx full", d, 32'h0000_1000);
    txpop(b); chk(b == 8'h50, "R3 tx head", b, 8'h50);
    wr(3'd0, 32'h0000_0002);
    peek(3'd2, d); chk(d[13:8] == 15, "R7 count before edge", d, 15);
    @(posedge clk); @(negedge clk);
    peek(3'd2, d); chk(d[13:8] == 0, "R7 emptied", d, 0);
    peek(3'd0, d); chk(d[0] == 0, "R7 disabled", d, 0);
    chk(tx_out_valid == 0, "R8 no tx valid disabled", tx_out_valid, 0);
  endtask

  task automatic t_rx_disabled;
    logic [31:0] d;
    wr(3'd1, 32'h0);
    @(negedge clk); rx_in_valid = 1; rx_in_data = 8'h99; #1;
    chk(rx_in_ready == 0 && rx_overrun == 0, "R8 rx disabled", {rx_in_ready, rx_overrun}, 0);
    @(posedge clk); @(negedge clk); rx_in_valid = 0;
    peek(3'd2, d); chk(d[5:0] == 0, "R8 rx push dropped", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_cfg();
    t_rx_order();
    t_rx_overrun();
    t_flush();
    t_tx();
    t_rx_disabled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule